// File: doc/BRIEF.md
# Four-Bin 24-Point DFT Accumulator Coprocessor

This coprocessor sits on a processor's word-addressed memory bus and turns a stream of 24 real samples into single-bin DFT results for the frequencies k = 1, 2, 3 and 4. These are the frequencies of one to four full periods per 24 samples. Four multiply-accumulate lanes work side by side and share one sample index counter. Each lane keeps a cosine sum and a sine sum. Its twiddle factors come from a fixed-point table built from a quarter-wave of constants.

Software drives the block through two word locations. Word 0 takes commands, which are flag bits at the top of the written word, and it also takes the sample that follows a "next sample" command. Word 1 is read-only and returns the sums. After a cosine or sine readout command, four reads of word 1 return the four bins in ascending order of k.

Top module: `dft4_copro`

## Requirements
- R1: After the synchronous `rst`, every accumulator, the sample index and the armed state are zero. `bus_rvalid` is low, and a read of word 1 returns 0.
- R2: `bus_ready` is always high. `bus_rvalid` is high in exactly the cycle after an accepted read. A read of any address other than word 1 returns 0.
- R3: A write of a command word to word 0 arms the block. The command word has bit 31 set and bits 30..28 clear. The next write to word 0 is taken as a signed 32-bit sample, whatever its top bits hold, and the block is then disarmed.
- R4: For a sample x at index i, each bin k adds (x*C)>>>14 to its cosine sum and (x*S)>>>14 to its sine sum. C and S are round(16384*cos(2πki/24)) and round(16384*sin(2πki/24)). The products are full width, the shift is arithmetic, and the sums wrap modulo 2^32.
- R5: All four bins take the same sample in the same cycle. Each sum is visible to a read issued on any later cycle.
- R6: The sample index advances by one per sample and wraps from 23 to 0. The 25th sample without a clear uses index 0 again.
- R7: Writing word 0 with bit 29 set (bit 30 clear) selects the cosine sums. The next four reads of word 1 return k = 1, 2, 3, 4 in that order, and later reads return 0.
- R8: Writing word 0 with bit 28 set (bits 30 and 29 clear) does the same for the sine sums.
- R9: Writing word 0 with bit 30 set clears all eight sums, the index, the armed state and any readout in progress, all in one cycle.
- R10: Command priority is bit 30, then bit 29, then bit 28, then bit 31. A word with a higher flag set never arms the block.
- R11: The following writes change nothing: a write to word 0 with bits 31..28 clear while not armed, and any write to an address other than word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Transfer request this cycle |
| bus_ready | output | 1 | Transfer accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |

## Verification
A wrong armed flag shows up at the next word 0 write. The write either turns a command into a sample, or it drops a sample, and every later bin sum then differs from the model. A wrong index or twiddle shows up as a wrong sum on the first readout after that sample. A stuck readout counter gives data in the wrong order, or nonzero data after the fourth read, on the very next read of word 1. The bench checks a readout after each stimulus pattern, so each of these faults is caught within one pattern.

// File: rtl/dft4_pkg.sv
package dft4_pkg;
    localparam int DATA_W   = 32;
    localparam int TW_W     = 16;
    localparam int TW_FRAC  = 14;
    localparam int N_PT     = 24;
    localparam int N_BIN    = 4;
    localparam int ADDR_W   = 4;
    localparam int IDX_W    = $clog2(N_PT);
    localparam int QTR      = N_PT / 4;
    localparam int CNT_W    = $clog2(N_BIN + 1);
    localparam int SEL_W    = $clog2(N_BIN);
    localparam int PROD_W   = DATA_W + TW_W;

    // flag positions inside a word written to word 0
    localparam int FLAG_DATA = 31;
    localparam int FLAG_CLR  = 30;
    localparam int FLAG_COS  = 29;
    localparam int FLAG_SIN  = 28;

    typedef logic signed [DATA_W-1:0] acc_t;
    typedef logic signed [TW_W-1:0]   tw_t;

    typedef enum logic {SEL_COS = 1'b0, SEL_SIN = 1'b1} rsel_e;

    typedef struct packed {
        logic clear;
        logic start_cos;
        logic start_sin;
        logic arm;
        logic sample;
    } cmd_t;

    // cos(2*pi*n/24) in Q1.14 for n = 0..6
    function automatic tw_t quarter_wave(input int n);
        case (n)
            0:       return tw_t'(16384);
            1:       return tw_t'(15826);
            2:       return tw_t'(14189);
            3:       return tw_t'(11585);
            4:       return tw_t'(8192);
            5:       return tw_t'(4240);
            default: return tw_t'(0);
        endcase
    endfunction

    function automatic tw_t tw_cos(input int n);
        int m;
        m = n % N_PT;
        if (m <= QTR)          return quarter_wave(m);
        else if (m <= 2 * QTR) return -quarter_wave(2 * QTR - m);
        else if (m <= 3 * QTR) return -quarter_wave(m - 2 * QTR);
        else                   return quarter_wave(N_PT - m);
    endfunction

    // sin(x) = cos(x - pi/2)
    function automatic tw_t tw_sin(input int n);
        return tw_cos(n + 3 * QTR);
    endfunction
endpackage

// File: rtl/dft4_ctrl.sv
module dft4_ctrl
    import dft4_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ready,
    output cmd_t              cmd,
    output acc_t              sample,
    output logic [IDX_W-1:0]  idx,
    output logic              rd_port,
    output logic              rd_any
);
    logic armed;
    logic wr0;

    assign ready   = 1'b1;
    assign wr0     = valid && write && (addr == '0);
    assign rd_any  = valid && !write;
    assign rd_port = rd_any && (addr == ADDR_W'(1));
    assign sample  = acc_t'(wdata);

    always_comb begin
        cmd = '0;
        if (wr0) begin
            if (armed)                 cmd.sample    = 1'b1;
            else if (wdata[FLAG_CLR])  cmd.clear     = 1'b1;
            else if (wdata[FLAG_COS])  cmd.start_cos = 1'b1;
            else if (wdata[FLAG_SIN])  cmd.start_sin = 1'b1;
            else if (wdata[FLAG_DATA]) cmd.arm       = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (cmd.arm) begin
            armed <= 1'b1;
        end else if (cmd.sample || cmd.clear) begin
            armed <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.clear) begin
            idx <= '0;
        end else if (cmd.sample) begin
            idx <= (idx == IDX_W'(N_PT - 1)) ? '0 : idx + IDX_W'(1);
        end
    end

    // R10: at most one action per accepted write
    a_r10_one_action: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd.clear, cmd.start_cos, cmd.start_sin, cmd.arm, cmd.sample}));
    // R3: the word after arming is consumed and disarms
    a_r3_disarm: assert property (@(posedge clk) disable iff (rst)
        (armed && wr0) |=> !armed);
    // R6: index stays in range and wraps
    a_r6_idx_range: assert property (@(posedge clk) disable iff (rst)
        idx < IDX_W'(N_PT));
    a_r6_idx_wrap: assert property (@(posedge clk) disable iff (rst)
        (cmd.sample && idx == IDX_W'(N_PT - 1)) |=> (idx == '0));
    // R9: clear resets the index and armed state
    a_r9_clear_ctrl: assert property (@(posedge clk) disable iff (rst)
        cmd.clear |=> (idx == '0 && !armed));
endmodule

// File: rtl/dft4_twiddle.sv
module dft4_twiddle
    import dft4_pkg::*;
#(
    parameter int BIN = 1
) (
    input  logic [IDX_W-1:0] idx,
    output tw_t              cos_w,
    output tw_t              sin_w
);
    int phase;

    always_comb begin
        phase = BIN * int'(idx);
        cos_w = tw_cos(phase);
        sin_w = tw_sin(phase);
    end
endmodule

// File: rtl/dft4_lane.sv
module dft4_lane
    import dft4_pkg::*;
#(
    parameter int BIN = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             strobe,
    input  logic [IDX_W-1:0] idx,
    input  acc_t             sample,
    output acc_t             acc_cos,
    output acc_t             acc_sin
);
    tw_t cw;
    tw_t sw;
    logic signed [PROD_W-1:0] prod_c;
    logic signed [PROD_W-1:0] prod_s;
    logic signed [PROD_W-1:0] shf_c;
    logic signed [PROD_W-1:0] shf_s;

    dft4_twiddle #(.BIN(BIN)) u_tw (
        .idx   (idx),
        .cos_w (cw),
        .sin_w (sw)
    );

    always_comb begin
        prod_c = sample * cw;
        prod_s = sample * sw;
        shf_c  = prod_c >>> TW_FRAC;
        shf_s  = prod_s >>> TW_FRAC;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_cos <= '0;
            acc_sin <= '0;
        end else if (strobe) begin
            acc_cos <= acc_cos + acc_t'(shf_c);
            acc_sin <= acc_sin + acc_t'(shf_s);
        end
    end

    // R9: clear empties both sums next cycle
    a_r9_clear_lane: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_cos == '0 && acc_sin == '0));
    // R11: sums only move on a sample
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!strobe && !clr) |=> ($stable(acc_cos) && $stable(acc_sin)));
endmodule

// File: rtl/dft4_readout.sv
module dft4_readout
    import dft4_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear,
    input  logic                  start_cos,
    input  logic                  start_sin,
    input  logic                  rd_port,
    input  logic                  rd_any,
    input  acc_t [N_BIN-1:0]      cos_sum,
    input  acc_t [N_BIN-1:0]      sin_sum,
    output logic [DATA_W-1:0]     rdata,
    output logic                  rvalid
);
    logic [CNT_W-1:0] cnt;
    rsel_e            sel;
    logic             live;

    assign live = cnt < CNT_W'(N_BIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= CNT_W'(N_BIN);
            sel    <= SEL_COS;
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_any;
            if (clear) begin
                cnt <= CNT_W'(N_BIN);
            end else if (start_cos) begin
                cnt <= '0;
                sel <= SEL_COS;
            end else if (start_sin) begin
                cnt <= '0;
                sel <= SEL_SIN;
            end
            if (rd_port && live) begin
                rdata <= (sel == SEL_COS) ? cos_sum[cnt[SEL_W-1:0]]
                                          : sin_sum[cnt[SEL_W-1:0]];
                cnt   <= cnt + CNT_W'(1);
            end else if (rd_any) begin
                rdata <= '0;
            end
        end
    end

    // R2: read data valid exactly one cycle after a read
    a_r2_rvalid_rise: assert property (@(posedge clk) disable iff (rst)
        rd_any |=> rvalid);
    a_r2_rvalid_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_any |=> !rvalid);
    // R7: drained readout returns zero
    a_r7_drained_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_port && !live) |=> (rdata == '0));
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(N_BIN));
endmodule

// File: rtl/dft4_copro.sv
module dft4_copro
    import dft4_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    output logic              bus_ready,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid
);
    cmd_t             cmd;
    acc_t             sample;
    logic [IDX_W-1:0] idx;
    logic             rd_port;
    logic             rd_any;
    acc_t [N_BIN-1:0] cos_sum;
    acc_t [N_BIN-1:0] sin_sum;

    dft4_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .valid   (bus_valid),
        .write   (bus_write),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .ready   (bus_ready),
        .cmd     (cmd),
        .sample  (sample),
        .idx     (idx),
        .rd_port (rd_port),
        .rd_any  (rd_any)
    );

    for (genvar b = 0; b < N_BIN; b++) begin : g_lane
        dft4_lane #(.BIN(b + 1)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .clr     (cmd.clear),
            .strobe  (cmd.sample),
            .idx     (idx),
            .sample  (sample),
            .acc_cos (cos_sum[b]),
            .acc_sin (sin_sum[b])
        );
    end

    dft4_readout u_rd (
        .clk       (clk),
        .rst       (rst),
        .clear     (cmd.clear),
        .start_cos (cmd.start_cos),
        .start_sin (cmd.start_sin),
        .rd_port   (rd_port),
        .rd_any    (rd_any),
        .cos_sum   (cos_sum),
        .sin_sum   (sin_sum),
        .rdata     (bus_rdata),
        .rvalid    (bus_rvalid)
    );

    // R2: the bus never stalls
    a_r2_ready: assert property (@(posedge clk) disable iff (rst) bus_ready);
    // R1: no read data without a read after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> !bus_rvalid);
endmodule

// File: tb/sim_dft4_copro.sv
`timescale 1ns/1ps
module sim_dft4_copro;
    localparam real PI = 3.14159265358979323846;
    localparam int  NV = 6;
    // {pattern kind, amplitude, sample count}
    localparam int TBL [NV][3] = '{
        '{0, 1000,       24},
        '{1, -3000,      24},
        '{2, 500,        24},
        '{3, 77777,      24},
        '{4, 123456,     30},
        '{1, 2000000000, 24}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_ready;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    int n_chk  = 0;
    int n_fail = 0;
    int mc [4];
    int ms [4];
    int mn;

    always #2 clk = ~clk;

    dft4_copro u0 (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int twc(input int k, input int i);
        return int'(16384.0 * $cos(2.0 * PI * k * i / 24.0));
    endfunction
    function automatic int tws(input int k, input int i);
        return int'(16384.0 * $sin(2.0 * PI * k * i / 24.0));
    endfunction

    function automatic int gen(input int kind, input int amp, input int i);
        case (kind)
            0:       return (i == 0) ? amp : 0;
            1:       return amp;
            2:       return amp * (i - 12);
            3:       return (i % 2 == 1) ? -amp : amp;
            default: return amp * (((i * 7) % 13) - 6);
        endcase
    endfunction

    task automatic model_clear();
        for (int k = 0; k < 4; k++) begin mc[k] = 0; ms[k] = 0; end
        mn = 0;
    endtask

    task automatic model_add(input int s);
        longint p;
        for (int k = 0; k < 4; k++) begin
            p = longint'(s) * longint'(twc(k + 1, mn % 24));
            mc[k] = mc[k] + int'(p >>> 14);
            p = longint'(s) * longint'(tws(k + 1, mn % 24));
            ms[k] = ms[k] + int'(p >>> 14);
        end
        mn++;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata; v = bus_rvalid;
    endtask

    task automatic feed(input int s);
        wr(4'd0, 32'h8000_0000);
        wr(4'd0, s);
        model_add(s);
    endtask

    // read four bins plus one drained read; R7 cosine, R8 sine
    task automatic read_bins(input bit sine, input string req);
        logic [31:0] d;
        logic v;
        wr(4'd0, sine ? 32'h1000_0000 : 32'h2000_0000);
        for (int k = 0; k < 4; k++) begin
            rd(4'd1, d, v);
            chk({req, " bin"}, d, sine ? ms[k] : mc[k]);
            chk("R2 rvalid after read", {31'd0, v}, 32'd1);
        end
        rd(4'd1, d, v);
        chk(sine ? "R8 drained zero" : "R7 drained zero", d, 32'd0);
    endtask

    initial begin
        #(4ns * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic v;
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        chk("R1 rvalid low", {31'd0, bus_rvalid}, 32'd0);
        chk("R2 ready high", {31'd0, bus_ready}, 32'd1);
        rd(4'd1, d, v);
        chk("R1 read zero", d, 32'd0);
        chk("R2 rvalid one cycle", {31'd0, v}, 32'd1);
        @(negedge clk);
        chk("R2 rvalid drops", {31'd0, bus_rvalid}, 32'd0);
        read_bins(1'b0, "R1 cos after reset");

        // vector table: R3 R4 R5 R6
        for (int t = 0; t < NV; t++) begin
            wr(4'd0, 32'h4000_0000);
            model_clear();
            for (int i = 0; i < TBL[t][2]; i++) feed(gen(TBL[t][0], TBL[t][1], i));
            read_bins(1'b0, "R4 R5 R6 R7 cos");
            read_bins(1'b1, "R4 R5 R6 R8 sin");
        end

        // R3: data word with flag bits set is still a sample
        wr(4'd0, 32'h4000_0000);
        model_clear();
        feed(32'h4000_0005);
        feed(32'hF000_0123);
        read_bins(1'b0, "R3 flagged data cos");
        read_bins(1'b1, "R3 flagged data sin");

        // R11: ignored writes
        wr(4'd1, 32'h8000_0000);
        wr(4'd0, 32'h0000_1234);
        wr(4'd5, 32'h8000_0000);
        wr(4'd0, 32'h0000_0777);
        read_bins(1'b0, "R11 ignored cos");

        // R2: read of a non-output address
        rd(4'd0, d, v);
        chk("R2 other addr zero", d, 32'd0);

        // R10: bit 29 beats bit 28; bit 29 beats bit 31 (no arming)
        wr(4'd0, 32'h3000_0000);
        for (int k = 0; k < 4; k++) begin
            rd(4'd1, d, v);
            chk("R10 cos over sin", d, mc[k]);
        end
        wr(4'd0, 32'hA000_0000);
        wr(4'd0, 32'h0000_0100);
        read_bins(1'b1, "R10 no arm");

        // R9: clear mid-readout
        wr(4'd0, 32'h2000_0000);
        rd(4'd1, d, v);
        chk("R9 pre-clear bin1", d, mc[0]);
        wr(4'd0, 32'h4000_0000);
        model_clear();
        rd(4'd1, d, v);
        chk("R9 readout aborted", d, 32'd0);
        read_bins(1'b1, "R9 cleared sin");

        // R10: clear beats readout flags; index restarts (R9)
        feed(32'd9000);
        wr(4'd0, 32'h7000_0000);
        model_clear();
        read_bins(1'b0, "R10 clear priority");
        feed(32'd5000);
        read_bins(1'b0, "R9 index restart");

        // R1: synchronous reset mid-run
        feed(32'd4444);
        wr(4'd0, 32'h8000_0000);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_clear();
        wr(4'd0, 32'h0000_2222);
        read_bins(1'b0, "R1 reset clears");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule